// File: doc/BRIEF.md
# Memory Caching Type Resolver

This block answers one question for a memory subsystem: given a physical address range, what caching type applies to it? A range is presented as a start address and an exclusive end address on the lookup port, and one clock later the block returns an 8-bit type code. The answer is drawn from four sources of configuration: a table of per-region type bytes covering the first megabyte, a parameterised set of programmable base/mask range registers, a default type with a two-bit enable field, and an optional top-of-memory limit that marks memory above 4 GiB as write-back.

Configuration arrives through a single write port. A select field chooses which kind of register is written, an index picks the table word or range number, and a 64-bit data word carries the value. Until the default/enable register has been written once after reset, every lookup reports "not configured". When several programmable ranges cover the same address, their types are merged by a fixed precedence; a range that covers only one end of the queried span is reported with a dedicated code so that software can split the request.

Type codes used throughout: uncacheable 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05, write-back 0x06, partial coverage 0xFE, not configured or disabled 0xFF.

Top module: `memtype_lookup`

## Requirements
- R1: A lookup presented with `lk_valid` high yields `res_valid` high exactly one clock later; `res_valid` is low in a cycle that follows a clock with `lk_valid` low, and after reset `res_valid` is 0 and `res_type` is 0xFF.
- R2: Until the default/enable register (write select 3) has been written after reset, every lookup returns 0xFF, even when other registers hold valid data.
- R3: When the enable field (data bits 11:10 of the default/enable register) is 0, every lookup returns 0xFF.
- R4: With the low table present and start below 0x100000, the result is the table byte chosen by start alone: entry start>>16 below 0x80000, entry 8+((start-0x80000)>>14) below 0xC0000, else entry 24+((start-0xC0000)>>12); table write select 0 with index w (0..10) stores byte b (data bits 8b+7:8b) as entry 8w+b; this applies whenever the enable field is nonzero.
- R5: When enable bit 11 (programmable ranges on) is clear and the low table does not apply, the result is the default type without regard to any range.
- R6: A programmable range takes part only if bit 11 of its mask word (select 2) is set; its type is bits 7:0 of its base word (select 1); an address matches when (addr & mask) equals (base & mask) on bits ADDR_W-1:12, bits 11:0 being ignored.
- R7: Ranges are visited in index order; the first valid range that matches exactly one of start and inclusive end makes the result 0xFE.
- R8: If two matching types meet and either is uncacheable (0), the result is uncacheable and the visit stops.
- R9: Write-back meeting write-through merges to write-through and the visit continues.
- R10: Any other pair of unequal matching types gives uncacheable and stops the visit.
- R11: The limit register (select 4) keeps only data bits ADDR_W-1:23; if it is nonzero and the visit did not stop early, a span with start at or above 4 GiB and inclusive end below the limit returns write-back.
- R12: When no valid range matches and the limit rule does not apply, the result is the default type, bits 7:0 of the default/enable register.
- R13: The end address is exclusive: matching and the limit comparison use end minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register kind: 0 table word, 1 range base, 2 range mask, 3 default/enable, 4 limit |
| cfg_idx | input | IDX_W | Table word or range number |
| cfg_wdata | input | 64 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_start | input | ADDR_W | First byte address of the span |
| lk_end | input | ADDR_W | Address one past the last byte of the span |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_type | output | 8 | Resolved type code |

## Verification
The bench probes the table index seams at 0x80000 and 0xC0000 and the last byte below 1 MiB; a wrong shift or offset returns a neighbouring entry's byte, which the bench makes visible by storing each entry's own index. It queries a span ending exactly on a range boundary, which a design that forgot to subtract one from the end would report as partial, and a span straddling that boundary, which must report 0xFE. Overlapping ranges are tested in all three merge outcomes, including the case where an early uncacheable result must survive the limit rule while a write-through merge must not. The limit is written with junk low bits so that a design that fails to mask it would wrongly grant write-back just above the limit.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

  typedef enum logic [2:0] {
    CFG_TABLE = 3'd0,
    CFG_BASE  = 3'd1,
    CFG_MASK  = 3'd2,
    CFG_DEFEN = 3'd3,
    CFG_LIMIT = 3'd4
  } cfg_sel_e;

  localparam logic [7:0] MT_UC      = 8'h00;
  localparam logic [7:0] MT_WC      = 8'h01;
  localparam logic [7:0] MT_WT      = 8'h04;
  localparam logic [7:0] MT_WP      = 8'h05;
  localparam logic [7:0] MT_WB      = 8'h06;
  localparam logic [7:0] MT_PARTIAL = 8'hFE;
  localparam logic [7:0] MT_NONE    = 8'hFF;

  localparam int PAGE_SHIFT  = 12;
  localparam int VALID_BIT   = 11;
  localparam int LIMIT_SHIFT = 23;
  localparam int LOW_SHIFT   = 20;

endpackage

// File: rtl/mt_fixed_table.sv
module mt_fixed_table #(
  parameter int WORDS = 11,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [63:0]      wdata,
  input  logic [7:0]       pg,
  output logic [7:0]       type_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);
  localparam int RD_W = $clog2(WORDS);

  logic [63:0] mem [WORDS];
  logic [6:0]  entry;
  logic [63:0] word;

  always_ff @(posedge clk) begin
    if (we && widx <= LAST) mem[widx] <= wdata;
  end

  // Entry selection: 64 KiB, 16 KiB and 4 KiB regions by the page bits.
  always_comb begin
    if (!pg[7])      entry = {4'b0, pg[6:4]};
    else if (!pg[6]) entry = 7'd8 + {3'b0, pg[5:2]};
    else             entry = 7'd24 + {1'b0, pg[5:0]};
  end

  always_comb begin
    word   = mem[entry[3+RD_W-1:3]];
    type_o = word[{entry[2:0], 3'b000} +: 8];
  end

endmodule

// File: rtl/mt_var_ranges.sv
module mt_var_ranges #(
  parameter int NUM_VAR = 8,
  parameter int PG_W    = 36,
  parameter int IDX_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    base_we,
  input  logic                    mask_we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [PG_W-1:0]         wpage,
  input  logic [7:0]              wtype,
  input  logic                    wvalid,
  input  logic [PG_W-1:0]         start_pg,
  input  logic [PG_W-1:0]         end_pg,
  output logic [NUM_VAR-1:0]      vld,
  output logic [NUM_VAR-1:0]      hit_s,
  output logic [NUM_VAR-1:0]      hit_e,
  output logic [NUM_VAR-1:0][7:0] typ
);

  for (genvar i = 0; i < NUM_VAR; i++) begin : g_rng
    logic [PG_W-1:0] base_q;
    logic [PG_W-1:0] mask_q;
    logic [7:0]      type_q;
    logic            vld_q;
    logic            sel;

    assign sel = (widx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (base_we && sel) begin
        base_q <= wpage;
        type_q <= wtype;
      end
      if (mask_we && sel) mask_q <= wpage;
    end

    always_ff @(posedge clk) begin
      if (rst)                  vld_q <= 1'b0;
      else if (mask_we && sel)  vld_q <= wvalid;
    end

    assign vld[i]   = vld_q;
    assign typ[i]   = type_q;
    assign hit_s[i] = ((start_pg ^ base_q) & mask_q) == '0;
    assign hit_e[i] = ((end_pg ^ base_q) & mask_q) == '0;
  end

endmodule

// File: rtl/mt_merge.sv
module mt_merge
  import memtype_pkg::*;
#(
  parameter int NUM_VAR = 8
) (
  input  logic [NUM_VAR-1:0]      vld,
  input  logic [NUM_VAR-1:0]      hit_s,
  input  logic [NUM_VAR-1:0]      hit_e,
  input  logic [NUM_VAR-1:0][7:0] typ,
  output logic                    partial,
  output logic                    early_uc,
  output logic [7:0]              acc
);
  logic       stop;
  logic [7:0] cur;

  always_comb begin
    acc      = MT_NONE;
    partial  = 1'b0;
    early_uc = 1'b0;
    stop     = 1'b0;
    cur      = MT_NONE;
    for (int i = 0; i < NUM_VAR; i++) begin
      if (!stop && vld[i]) begin
        if (hit_s[i] != hit_e[i]) begin
          partial = 1'b1;
          stop    = 1'b1;
        end else if (hit_s[i]) begin
          cur = typ[i];
          if (acc == MT_NONE) begin
            acc = cur;
          end else if (acc == MT_UC || cur == MT_UC) begin
            acc      = MT_UC;
            early_uc = 1'b1;
            stop     = 1'b1;
          end else begin
            if ((acc == MT_WB && cur == MT_WT) || (acc == MT_WT && cur == MT_WB)) begin
              acc = MT_WT;
              cur = MT_WT;
            end
            if (acc != cur) begin
              acc      = MT_UC;
              early_uc = 1'b1;
              stop     = 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/memtype_lookup.sv
module memtype_lookup
  import memtype_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int NUM_VAR   = 8,
  parameter int IDX_W     = 4,
  parameter int TBL_WORDS = 11,
  parameter bit HAS_LOW   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [63:0]       cfg_wdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_start,
  input  logic [ADDR_W-1:0] lk_end,
  output logic              res_valid,
  output logic [7:0]        res_type
);
  localparam int PG_W = ADDR_W - PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] LIMIT_KEEP =
    {{(ADDR_W-LIMIT_SHIFT){1'b1}}, {LIMIT_SHIFT{1'b0}}};

  logic              loaded_q;
  logic [1:0]        en_q;
  logic [7:0]        def_q;
  logic [ADDR_W-1:0] limit_q;

  logic [ADDR_W-1:0] end_incl;
  logic              in_low, above_4g, limit_hit;
  logic [7:0]        low_type;
  logic [NUM_VAR-1:0]      v_vld, v_hs, v_he;
  logic [NUM_VAR-1:0][7:0] v_typ;
  logic              partial, early_uc;
  logic [7:0]        acc;
  logic [7:0]        nxt;
  logic              unused_bits;

  assign unused_bits = ^{cfg_wdata, lk_start[PAGE_SHIFT-1:0]};

  // Default/enable and limit registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_q <= 1'b0;
      en_q     <= 2'b00;
      def_q    <= MT_UC;
      limit_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == CFG_DEFEN) begin
        loaded_q <= 1'b1;
        en_q     <= cfg_wdata[11:10];
        def_q    <= cfg_wdata[7:0];
      end
      if (cfg_sel == CFG_LIMIT) limit_q <= cfg_wdata[ADDR_W-1:0] & LIMIT_KEEP;
    end
  end

  assign end_incl  = lk_end - {{(ADDR_W-1){1'b0}}, 1'b1};
  assign in_low    = (lk_start[ADDR_W-1:LOW_SHIFT] == '0);
  assign above_4g  = (lk_start[ADDR_W-1:32] != '0);
  assign limit_hit = (limit_q != '0) && above_4g && (end_incl < limit_q);

  if (HAS_LOW) begin : g_low
    mt_fixed_table #(.WORDS(TBL_WORDS), .IDX_W(IDX_W)) u_tbl (
      .clk    (clk),
      .we     (cfg_we && cfg_sel == CFG_TABLE),
      .widx   (cfg_idx),
      .wdata  (cfg_wdata),
      .pg     (lk_start[LOW_SHIFT-1:PAGE_SHIFT]),
      .type_o (low_type)
    );
  end else begin : g_nolow
    assign low_type = MT_NONE;
  end

  mt_var_ranges #(.NUM_VAR(NUM_VAR), .PG_W(PG_W), .IDX_W(IDX_W)) u_rng (
    .clk      (clk),
    .rst      (rst),
    .base_we  (cfg_we && cfg_sel == CFG_BASE),
    .mask_we  (cfg_we && cfg_sel == CFG_MASK),
    .widx     (cfg_idx),
    .wpage    (cfg_wdata[ADDR_W-1:PAGE_SHIFT]),
    .wtype    (cfg_wdata[7:0]),
    .wvalid   (cfg_wdata[VALID_BIT]),
    .start_pg (lk_start[ADDR_W-1:PAGE_SHIFT]),
    .end_pg   (end_incl[ADDR_W-1:PAGE_SHIFT]),
    .vld      (v_vld),
    .hit_s    (v_hs),
    .hit_e    (v_he),
    .typ      (v_typ)
  );

  mt_merge #(.NUM_VAR(NUM_VAR)) u_merge (
    .vld      (v_vld),
    .hit_s    (v_hs),
    .hit_e    (v_he),
    .typ      (v_typ),
    .partial  (partial),
    .early_uc (early_uc),
    .acc      (acc)
  );

  always_comb begin
    if (!loaded_q || en_q == 2'b00)  nxt = MT_NONE;
    else if (HAS_LOW && in_low)      nxt = low_type;
    else if (!en_q[1])               nxt = def_q;
    else if (partial)                nxt = MT_PARTIAL;
    else if (early_uc)               nxt = MT_UC;
    else if (limit_hit)              nxt = MT_WB;
    else if (acc != MT_NONE)         nxt = acc;
    else                             nxt = def_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_type  <= MT_NONE;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) res_type <= nxt;
    end
  end

endmodule

// File: rtl/memtype_lookup_chk.sv
module memtype_lookup_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [2:0]        cfg_sel,
  input logic [11:0]       cfg_wd,
  input logic              lk_valid,
  input logic [ADDR_W-21:0] lk_start_hi,
  input logic              res_valid,
  input logic [7:0]        res_type
);
  logic       seen;
  logic [1:0] en_t;
  logic [7:0] def_t;
  logic       unused_chk;

  assign unused_chk = ^cfg_wd[9:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      seen  <= 1'b0;
      en_t  <= 2'b00;
      def_t <= 8'h00;
    end else if (cfg_we && cfg_sel == 3'd3) begin
      seen  <= 1'b1;
      en_t  <= cfg_wd[11:10];
      def_t <= cfg_wd[7:0];
    end
  end

  // R1
  res_follow_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  // R1
  res_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);

  // R2
  unloaded_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !seen) |=> (res_type == 8'hFF));

  // R3
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && seen && en_t == 2'b00) |=> (res_type == 8'hFF));

  // R4
  low_no_partial_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && seen && en_t != 2'b00 && lk_start_hi == '0) |=> (res_type != 8'hFE));

  // R5
  var_off_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && seen && en_t == 2'b01 && lk_start_hi != '0) |=> (res_type == $past(def_t)));

endmodule

bind memtype_lookup memtype_lookup_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_wd      (cfg_wdata[11:0]),
  .lk_valid    (lk_valid),
  .lk_start_hi (lk_start[ADDR_W-1:20]),
  .res_valid   (res_valid),
  .res_type    (res_type)
);

// File: tb/memtype_lookup_tb_top.sv
`timescale 1ns/1ps
module memtype_lookup_tb_top;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_sel = 3'd0;
  logic [IDX_W-1:0]  cfg_idx = '0;
  logic [63:0]       cfg_wdata = '0;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_start = '0;
  logic [ADDR_W-1:0] lk_end = '0;
  logic              res_valid;
  logic [7:0]        res_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  memtype_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_start(lk_start), .lk_end(lk_end),
    .res_valid(res_valid), .res_type(res_type)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input int idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IDX_W'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive one lookup, sample the registered result one edge later.
  task automatic look(input string req, input logic [ADDR_W-1:0] s,
                      input logic [ADDR_W-1:0] e, input logic [7:0] exp);
    @(negedge clk);
    lk_valid = 1'b1; lk_start = s; lk_end = e;
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " valid"}, 64'(res_valid), 64'd1);
    check(req, 64'(res_type), 64'(exp));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset valid", 64'(res_valid), 64'd0);
    check("R1 reset type", 64'(res_type), 64'hFF);
  endtask

  task automatic t_program();
    for (int w = 0; w < 11; w++) begin
      logic [63:0] d;
      for (int b = 0; b < 8; b++) d[8*b +: 8] = 8'(8*w + b);
      wr(3'd0, w, d);
    end
    wr(3'd1, 0, 64'h0000_0001_0000_0006); wr(3'd2, 0, 64'h0000_FFFF_F000_0800);
    wr(3'd1, 1, 64'h0000_0001_0800_0004); wr(3'd2, 1, 64'h0000_FFFF_FC00_0800);
    wr(3'd1, 2, 64'h0000_0002_0000_0001); wr(3'd2, 2, 64'h0000_FFFF_FF00_0800);
    wr(3'd1, 3, 64'h0000_0002_0000_0000); wr(3'd2, 3, 64'h0000_FFFF_FE00_0800);
    wr(3'd1, 4, 64'h0000_0004_0000_0005); wr(3'd2, 4, 64'h0000_FFFF_FF00_0000);
    wr(3'd1, 5, 64'h0000_0003_0000_0001); wr(3'd2, 5, 64'h0000_FFFF_FF00_0800);
    wr(3'd1, 6, 64'h0000_0003_0000_0005); wr(3'd2, 6, 64'h0000_FFFF_FF00_0800);
  endtask

  task automatic t_unloaded();
    look("R2 unloaded range", 48'h1_0000_0000, 48'h1_0000_1000, 8'hFF);
    look("R2 unloaded low", 48'h0, 48'h1000, 8'hFF);
    @(negedge clk);
    check("R1 idle drop", 64'(res_valid), 64'd0);
  endtask

  task automatic t_low();
    look("R4 first", 48'h00000, 48'h01000, 8'd0);
    look("R4 64k", 48'h10000, 48'h11000, 8'd1);
    look("R4 below 80000", 48'h7FFFF, 48'h80000, 8'd7);
    look("R4 at 80000", 48'h80000, 48'h81000, 8'd8);
    look("R4 16k step", 48'h84000, 48'h85000, 8'd9);
    look("R4 below C0000", 48'hBFFFF, 48'hC0000, 8'd23);
    look("R4 at C0000", 48'hC0000, 48'hC1000, 8'd24);
    look("R4 last", 48'hFFFFF, 48'h100000, 8'd87);
    look("R4 start only", 48'h10000, 48'h1_0000_0000, 8'd1);
  endtask

  task automatic t_var();
    look("R6 single", 48'h1_0000_0ABC, 48'h1_0000_0ABD, 8'h06);
    look("R9 wb wt", 48'h1_0800_0000, 48'h1_0800_1000, 8'h04);
    look("R8 uc wins", 48'h2_0000_0000, 48'h2_0000_1000, 8'h00);
    look("R10 mismatch", 48'h3_0000_0000, 48'h3_0000_1000, 8'h00);
    look("R6 invalid ignored", 48'h4_0000_0000, 48'h4_0000_1000, 8'h07);
    look("R12 no match", 48'h8000_0000, 48'h8000_1000, 8'h07);
    look("R7 partial", 48'h1_0FFF_F000, 48'h1_1000_1000, 8'hFE);
    look("R13 exclusive end", 48'h1_0FFF_F000, 48'h1_1000_0000, 8'h06);
  endtask

  task automatic t_limit();
    wr(3'd4, 0, 64'h0000_0008_00BF_FFFF);
    look("R11 above 4G", 48'h5_0000_0000, 48'h5_0000_1000, 8'h06);
    look("R11 R13 last page", 48'h8_007F_F000, 48'h8_0080_0000, 8'h06);
    look("R11 masked limit", 48'h8_0080_0000, 48'h8_0080_1000, 8'h07);
    look("R11 below 4G", 48'h8000_0000, 48'h8000_1000, 8'h07);
    look("R11 early uc kept", 48'h2_0000_0000, 48'h2_0000_1000, 8'h00);
    look("R11 overrides merge", 48'h1_0800_0000, 48'h1_0800_1000, 8'h06);
  endtask

  task automatic t_enable();
    wr(3'd3, 0, 64'h407);
    look("R5 ranges off", 48'h1_0000_0000, 48'h1_0000_1000, 8'h07);
    look("R5 low still on", 48'h10000, 48'h11000, 8'd1);
    wr(3'd3, 0, 64'h007);
    look("R3 enable zero", 48'h1_0000_0000, 48'h1_0000_1000, 8'hFF);
    look("R3 enable zero low", 48'h10000, 48'h11000, 8'hFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_program();
    t_unloaded();
    wr(3'd3, 0, 64'hC07);
    t_low();
    t_var();
    t_limit();
    t_enable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule